// File: doc/BRIEF.md
# Length-Decoded Serial Register Loader

This block is the serial write port of a frequency synthesizer control chip. A host pulls the active-low select low, clocks data in most significant bit first, and releases the select. The port counts the serial clock pulses in that frame. When the select is released, that count alone picks the destination register. No address or steering bits exist, so every bit in a frame is payload. The block holds three registers: an 8-bit configuration word, a 16-bit divide ratio and a 15-bit reference ratio.

The serial clock, select and data pins are synchronized into a fast system clock, and their edges are detected there. While a frame is open, the port also presents the contents of its shift chain on a serial output. It updates that output on each falling edge of the serial clock and drives it only while a frame is open. A pad wrapper combines the data and enable outputs into a three-state pin. When a destination register is written, a single-cycle strobe for that register fires.

Top module: `lenDecodeLoader`

## Requirements
- R1: After synchronous reset, all three registers read zero, no load strobe is high and the serial output enable is low.
- R2: Data is captured on each rising serial clock edge inside a frame, most significant bit first. A frame of exactly 8 clocks writes the configuration register, with the last captured bit in bit 0.
- R3: A frame of exactly 16 clocks writes the divide register, with the last captured bit in bit 0.
- R4: A frame of exactly 15 clocks writes the reference register, with the last captured bit in bit 0.
- R5: A frame of exactly 24 clocks writes the reference register with only the last 15 captured bits. The first 9 bits are discarded.
- R6: Frames of any other length, including zero clocks, leave all three registers unchanged and produce no strobe.
- R7: The clock count saturates above 32. A frame of 72 clocks, which a 6-bit wrapping counter would see as 8, writes nothing.
- R8: While a frame is being shifted, all three registers hold their previous values. They change only after the select is released.
- R9: Each register write is signalled by exactly one single-cycle strobe for that register. The strobe is high in the first cycle the new value is visible.
- R10: The serial output enable is high only while a frame is open. After the k-th falling serial clock edge of a frame, the serial output equals the bit captured at rising edge k-15 when k is at least 16, and 0 otherwise.
- R11: A select transition seen while the serial clock is high takes effect only once the serial clock is low. A frame neither opens nor closes during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclkIn | input | 1 | Serial clock pin, asynchronous |
| selN | input | 1 | Active-low frame select pin, asynchronous |
| sdIn | input | 1 | Serial data pin, asynchronous |
| sdOut | output | 1 | Serial output data from the shift chain |
| sdOutEn | output | 1 | Drive enable for the three-state serial output |
| cfgReg | output | 8 | Configuration register |
| divReg | output | 16 | Divide register |
| refReg | output | 15 | Reference register |
| cfgLoad | output | 1 | One-cycle strobe: configuration register written |
| divLoad | output | 1 | One-cycle strobe: divide register written |
| refLoad | output | 1 | One-cycle strobe: reference register written |

## Verification
The hardest cases to reach are the select edges that land while the serial clock is high, and the long frame whose length would alias onto a valid count if the counter wrapped. The bench drops the select while holding the serial clock high and confirms that no frame opens until the clock falls. It also raises the select right after a final rising edge and confirms the registers stay put until the clock is lowered. A 72-clock frame covers the aliasing case, and a 24-clock frame with a distinct leading pattern covers both bit discarding and the delayed serial output.

// File: rtl/lenLoaderPkg.sv
package lenLoaderPkg;

  // Control-to-datapath strobes, all valid for a single system clock cycle.
  typedef struct packed {
    logic clear;    // frame opens: empty the chain and output bit
    logic shift;    // rising serial edge: capture one data bit
    logic outStep;  // falling serial edge: advance the output bit
    logic loadCfg;  // frame closed with the configuration length
    logic loadDiv;  // frame closed with the divide length
    logic loadRef;  // frame closed with a reference length
  } ctlStrobe_t;

endpackage

// File: rtl/lenSync.sv
module lenSync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : gStage
    if (g == 0) begin : gFirst
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= d;
      end
    end else begin : gNext
      always_ff @(posedge clk) begin
        if (rst) stg[g] <= RST_VAL;
        else     stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];

endmodule

// File: rtl/lenLoaderCtrl.sv
module lenLoaderCtrl
  import lenLoaderPkg::*;
#(
  parameter int CFG_W = 8,
  parameter int DIV_W = 16,
  parameter int REF_W = 15,
  parameter int REF_LONG = 24,
  parameter int CNT_SAT = 33
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sclkS,
  input  logic       selS,
  output ctlStrobe_t ctl,
  output logic       frameActive
);

  localparam int CNT_W = $clog2(CNT_SAT + 1);
  localparam logic [CNT_W-1:0] SAT_V  = CNT_W'(CNT_SAT);
  localparam logic [CNT_W-1:0] CFG_V  = CNT_W'(CFG_W);
  localparam logic [CNT_W-1:0] DIV_V  = CNT_W'(DIV_W);
  localparam logic [CNT_W-1:0] REF_V  = CNT_W'(REF_W);
  localparam logic [CNT_W-1:0] REFL_V = CNT_W'(REF_LONG);

  logic             sclkPrev;
  logic [CNT_W-1:0] count;
  logic             sclkRise, sclkFall, startFrame, endFrame;

  // Select changes act only while the serial clock is low.
  assign startFrame = !frameActive && !selS && !sclkS;
  assign endFrame   =  frameActive &&  selS && !sclkS;
  assign sclkRise   =  frameActive &&  sclkS && !sclkPrev;
  assign sclkFall   =  frameActive && !sclkS &&  sclkPrev;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclkPrev    <= 1'b0;
      frameActive <= 1'b0;
      count       <= '0;
    end else begin
      sclkPrev <= sclkS;
      if (startFrame) begin
        frameActive <= 1'b1;
        count       <= '0;
      end else if (endFrame) begin
        frameActive <= 1'b0;
      end else if (sclkRise && count != SAT_V) begin
        count <= count + 1'b1;
      end
    end
  end

  always_comb begin
    ctl         = '0;
    ctl.clear   = startFrame;
    ctl.shift   = sclkRise;
    ctl.outStep = sclkFall;
    if (endFrame) begin
      ctl.loadCfg = (count == CFG_V);
      ctl.loadDiv = (count == DIV_V);
      ctl.loadRef = (count == REF_V) || (count == REFL_V);
    end
  end

  assert_count_sat_R7: assert property (@(posedge clk) disable iff (rst)
    count <= SAT_V);

  assert_one_target_R9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl.loadCfg, ctl.loadDiv, ctl.loadRef}));

  assert_load_closes_R6: assert property (@(posedge clk) disable iff (rst)
    (ctl.loadCfg || ctl.loadDiv || ctl.loadRef) |=> !frameActive);

endmodule

// File: rtl/lenLoaderData.sv
module lenLoaderData
  import lenLoaderPkg::*;
#(
  parameter int CFG_W = 8,
  parameter int DIV_W = 16,
  parameter int REF_W = 15,
  parameter int CHAIN_W = 24,
  parameter int OUT_TAP = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  ctlStrobe_t       ctl,
  input  logic             sdS,
  output logic             outBit,
  output logic [CFG_W-1:0] cfgReg,
  output logic [DIV_W-1:0] divReg,
  output logic [REF_W-1:0] refReg,
  output logic             cfgLoad,
  output logic             divLoad,
  output logic             refLoad
);

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst || ctl.clear) begin
      chain  <= '0;
      outBit <= 1'b0;
    end else begin
      if (ctl.shift)   chain  <= {chain[CHAIN_W-2:0], sdS};
      if (ctl.outStep) outBit <= chain[OUT_TAP];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfgReg  <= '0;
      divReg  <= '0;
      refReg  <= '0;
      cfgLoad <= 1'b0;
      divLoad <= 1'b0;
      refLoad <= 1'b0;
    end else begin
      cfgLoad <= ctl.loadCfg;
      divLoad <= ctl.loadDiv;
      refLoad <= ctl.loadRef;
      if (ctl.loadCfg) cfgReg <= chain[CFG_W-1:0];
      if (ctl.loadDiv) divReg <= chain[DIV_W-1:0];
      if (ctl.loadRef) refReg <= chain[REF_W-1:0];
    end
  end

  assert_hold_while_shift_R8: assert property (@(posedge clk) disable iff (rst)
    ctl.shift |=> ($stable(cfgReg) && $stable(divReg) && $stable(refReg)));

  assert_out_edge_only_R10: assert property (@(posedge clk) disable iff (rst)
    (!ctl.outStep && !ctl.clear) |=> $stable(outBit));

endmodule

// File: rtl/lenDecodeLoader.sv
module lenDecodeLoader
  import lenLoaderPkg::*;
#(
  parameter int CFG_W = 8,
  parameter int DIV_W = 16,
  parameter int REF_W = 15,
  parameter int REF_LONG = 24,
  parameter int CNT_SAT = 33,
  parameter int OUT_TAP = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sclkIn,
  input  logic             selN,
  input  logic             sdIn,
  output logic             sdOut,
  output logic             sdOutEn,
  output logic [CFG_W-1:0] cfgReg,
  output logic [DIV_W-1:0] divReg,
  output logic [REF_W-1:0] refReg,
  output logic             cfgLoad,
  output logic             divLoad,
  output logic             refLoad
);

  localparam int CHAIN_W = REF_LONG;

  ctlStrobe_t ctl;
  logic       sclkS, selS, sdS, frameActive;

  lenSync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({sclkIn, selN, sdIn}),
    .q   ({sclkS, selS, sdS})
  );

  lenLoaderCtrl #(
    .CFG_W(CFG_W), .DIV_W(DIV_W), .REF_W(REF_W),
    .REF_LONG(REF_LONG), .CNT_SAT(CNT_SAT)
  ) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .sclkS       (sclkS),
    .selS        (selS),
    .ctl         (ctl),
    .frameActive (frameActive)
  );

  lenLoaderData #(
    .CFG_W(CFG_W), .DIV_W(DIV_W), .REF_W(REF_W),
    .CHAIN_W(CHAIN_W), .OUT_TAP(OUT_TAP)
  ) u_data (
    .clk     (clk),
    .rst     (rst),
    .ctl     (ctl),
    .sdS     (sdS),
    .outBit  (sdOut),
    .cfgReg  (cfgReg),
    .divReg  (divReg),
    .refReg  (refReg),
    .cfgLoad (cfgLoad),
    .divLoad (divLoad),
    .refLoad (refLoad)
  );

  assign sdOutEn = frameActive;

endmodule

// File: tb/lenDecodeLoader_bench.sv
module lenDecodeLoader_bench;

  localparam int HALF = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sclkIn = 1'b0;
  logic selN = 1'b1;
  logic sdIn = 1'b0;
  logic sdOut, sdOutEn, cfgLoad, divLoad, refLoad;
  logic [7:0]  cfgReg;
  logic [15:0] divReg;
  logic [14:0] refReg;

  int nChecks = 0;
  int nFails = 0;
  int nCfg = 0, nDiv = 0, nRef = 0;
  logic [7:0]  expCfg = '0;
  logic [15:0] expDiv = '0;
  logic [14:0] expRef = '0;

  always #10 clk = ~clk;

  lenDecodeLoader u_lenDecodeLoader (
    .clk(clk), .rst(rst), .sclkIn(sclkIn), .selN(selN), .sdIn(sdIn),
    .sdOut(sdOut), .sdOutEn(sdOutEn), .cfgReg(cfgReg), .divReg(divReg),
    .refReg(refReg), .cfgLoad(cfgLoad), .divLoad(divLoad), .refLoad(refLoad)
  );

  always @(posedge clk) begin
    if (cfgLoad) nCfg++;
    if (divLoad) nDiv++;
    if (refLoad) nRef++;
  end

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkRegs(input string req);
    check(req, 32'(cfgReg), 32'(expCfg));
    check(req, 32'(divReg), 32'(expDiv));
    check(req, 32'(refReg), 32'(expRef));
  endtask

  // One frame of n clocks, MSB of word[n-1:0] first.
  task automatic runFrame(input logic [79:0] word, input int n, input string req,
                          input bit startHigh, input bit lateEnd, input bit checkOut);
    int c0, d0, r0;
    bit wCfg, wDiv, wRef;
    c0 = nCfg; d0 = nDiv; r0 = nRef;
    if (startHigh) begin
      sclkIn = 1'b1; waitClk(HALF);
      selN = 1'b0; waitClk(2 * HALF);
      check("R11 start deferred", 32'(sdOutEn), 32'd0);
      sclkIn = 1'b0; waitClk(HALF);
      check("R11 start after low", 32'(sdOutEn), 32'd1);
    end else begin
      selN = 1'b0; waitClk(HALF);
      check("R10 enable in frame", 32'(sdOutEn), 32'd1);
    end
    for (int i = n - 1; i >= 0; i--) begin
      int k;
      sdIn = word[i]; waitClk(HALF);
      sclkIn = 1'b1; waitClk(HALF);
      if (i == 0) begin
        check({"R8 hold mid-frame ", req}, 32'(nCfg + nDiv + nRef), 32'(c0 + d0 + r0));
        checkRegs("R8 hold mid-frame");
      end else begin
        sclkIn = 1'b0; waitClk(HALF);
        k = n - i;
        if (checkOut)
          check("R10 serial out", 32'(sdOut), (k >= 16) ? 32'(word[n - (k - 15)]) : 32'd0);
      end
    end
    if (lateEnd) begin
      selN = 1'b1; waitClk(2 * HALF);
      check("R11 end deferred", 32'(nCfg + nDiv + nRef), 32'(c0 + d0 + r0));
      checkRegs("R11 end deferred");
      sclkIn = 1'b0; waitClk(HALF + 4);
    end else begin
      sclkIn = 1'b0; waitClk(HALF);
      selN = 1'b1; waitClk(HALF + 4);
    end
    wCfg = (n == 8); wDiv = (n == 16); wRef = (n == 15) || (n == 24);
    if (wCfg) expCfg = word[7:0];
    if (wDiv) expDiv = word[15:0];
    if (wRef) expRef = word[14:0];
    checkRegs(req);
    check({req, " R9 cfg strobes"}, 32'(nCfg - c0), 32'(wCfg));
    check({req, " R9 div strobes"}, 32'(nDiv - d0), 32'(wDiv));
    check({req, " R9 ref strobes"}, 32'(nRef - r0), 32'(wRef));
    check("R10 enable idle", 32'(sdOutEn), 32'd0);
  endtask

  task automatic testReset();
    check("R1 cfg", 32'(cfgReg), 0);
    check("R1 div", 32'(divReg), 0);
    check("R1 ref", 32'(refReg), 0);
    check("R1 strobes", 32'({cfgLoad, divLoad, refLoad}), 0);
    check("R1 enable", 32'(sdOutEn), 0);
  endtask

  task automatic testLengths();
    runFrame(80'hA5, 8, "R2 cfg", 0, 0, 0);
    runFrame(80'h3C, 8, "R2 cfg again", 0, 0, 0);
    runFrame(80'hBEEF, 16, "R3 div", 0, 0, 0);
    runFrame(80'h5A3C, 15, "R4 ref15", 0, 0, 0);
    runFrame(80'hFF_D2B4, 24, "R5 ref24", 0, 0, 1);
  endtask

  task automatic testBadLengths();
    runFrame(80'h0, 0, "R6 len0", 0, 0, 0);
    runFrame(80'h7F, 7, "R6 len7", 0, 0, 0);
    runFrame(80'h3FFF, 14, "R6 len14", 0, 0, 0);
    runFrame(80'h1FFFF, 17, "R6 len17", 0, 0, 0);
    runFrame(80'hFFFF_FFFF_FFFF_FFFF_FF, 72, "R7 len72", 0, 0, 0);
  endtask

  task automatic testDeferred();
    runFrame(80'h96, 8, "R11 cfg", 1, 1, 0);
  endtask

  initial begin
    waitClk(5);
    rst = 1'b0;
    waitClk(2);
    testReset();
    testLengths();
    testBadLengths();
    testDeferred();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule